// File: doc/BRIEF.md
# Multi-Mode 16-bit Waveform Timer Core

This block is a configurable up/down counter that produces pulse-width and frequency waveforms. A 4-bit mode value selects one of sixteen behaviours. The mode chooses the limit the counter turns at (a fixed value, the full range, a programmable limit register, or compare register A). It chooses whether the count runs in one direction and wraps, or climbs and falls. It also chooses when the double-buffered compare values become active and on which event the sticky overflow flag sets. The count advances by one step on each cycle in which the `tick` input is high.

Software writes the mode as two 2-bit halves, each through its own strobe, and writes the two compare values and the limit register over a shared data bus. A downstream waveform stage uses the outputs: the count, the direction, one-cycle match pulses for both compare channels, pulses at the turning limit and at zero, and the overflow flag.

Top module: `pwm_timer_core`

## Requirements
- R1: After reset the count, the direction, the mode, all compare and limit registers and the overflow flag are zero.
- R2: With mode 0 the count rises by one on each tick, goes from 0xFFFF to 0 on the next tick, and holds when `tick` is low. `at_top` is high during a tick at count 0xFFFF.
- R3: Modes 4 and 12 return the count to 0 on the tick after it equals the limit. The limit is active compare A in mode 4 and the limit register in mode 12. `at_top` is high during that tick.
- R4: Modes 1 and 5 use a limit of 0x00FF, modes 2 and 6 use 0x01FF, and modes 3 and 7 use 0x03FF.
- R5: Modes 5, 6, 7, 14 and 15 count up and wrap from the limit to 0. `at_bottom` is high during a tick at count 0.
- R6: Modes 1, 2, 3, 8, 9, 10 and 11 count up to the limit and then down to 0, and turn at each end. `dir_down` is 1 while the count falls.
- R7: A compare write takes effect at once in modes 0, 4 and 12. In modes 5–7 and 14–15 the written value is held and becomes active on the tick at count 0. In modes 1–3 and 10–11 it becomes active on the tick at the limit. In modes 8–9 it becomes active on the tick at count 0 while falling.
- R8: The overflow flag sets on the tick at 0xFFFF in modes 0, 4 and 12, on the tick at the limit in single-slope PWM modes, and on the falling tick at 0 in dual-slope modes. It stays set until `ovf_clr` is high for one cycle. A set in the same cycle wins over the clear.
- R9: `match_a` and `match_b` are high during a tick whose count equals the active compare A or B value.
- R10: Mode 13 is reserved. The count and direction hold, and no event pulses are raised.
- R11: Modes 8, 10 and 14 take their limit from the limit register. Modes 9, 11 and 15 take it from the active compare A value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable for one step |
| wr_mode_lo | input | 1 | Write `wdata[1:0]` into mode bits 1:0 |
| wr_mode_hi | input | 1 | Write `wdata[1:0]` into mode bits 3:2 |
| wr_cmpa | input | 1 | Write `wdata` to compare A |
| wr_cmpb | input | 1 | Write `wdata` to compare B |
| wr_top | input | 1 | Write `wdata` to the limit register |
| wdata | input | 16 | Shared write data |
| ovf_clr | input | 1 | Clear the overflow flag |
| count | output | 16 | Current count |
| dir_down | output | 1 | 1 while a dual-slope count falls |
| match_a | output | 1 | Compare A match pulse |
| match_b | output | 1 | Compare B match pulse |
| at_top | output | 1 | Tick at the limit |
| at_bottom | output | 1 | Tick at the bottom turn |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
A wrong limit selection shows within one waveform period. The count then wraps or turns at the wrong value, so it is caught at the turning tick. A buffered compare value that loads at the wrong event shows as a match pulse one period early or late. That is why the bench writes compare values in mid-period and looks for the match on both sides of the update point. A misrouted overflow event shows as a flag set or missing right after the limit or the bottom turn, or as a flag that falls without a clear.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  typedef enum logic [2:0] {
    LIM_FULL, LIM_8B, LIM_9B, LIM_10B, LIM_REG, LIM_CMPA
  } lim_src_e;

  typedef enum logic [1:0] {UPD_NOW, UPD_AT_LIM, UPD_AT_ZERO} upd_pt_e;

  typedef enum logic [1:0] {OVF_AT_FULL, OVF_AT_LIM, OVF_AT_ZERO} ovf_pt_e;

  typedef struct packed {
    lim_src_e lim_src;
    logic     dual;
    logic     run;
    upd_pt_e  upd;
    ovf_pt_e  ovf;
  } mode_cfg_t;

  localparam logic [3:0] MODE_RESERVED = 4'd13;

  function automatic mode_cfg_t decode_mode(logic [3:0] m);
    mode_cfg_t c;
    c = '{lim_src: LIM_FULL, dual: 1'b0, run: 1'b1, upd: UPD_NOW, ovf: OVF_AT_FULL};
    case (m)
      4'd0:  c.lim_src = LIM_FULL;
      4'd4:  c.lim_src = LIM_CMPA;
      4'd12: c.lim_src = LIM_REG;
      4'd1, 4'd2, 4'd3, 4'd10, 4'd11: begin
        c.dual = 1'b1;
        c.upd  = UPD_AT_LIM;
        c.ovf  = OVF_AT_ZERO;
        c.lim_src = (m == 4'd1) ? LIM_8B : (m == 4'd2) ? LIM_9B :
                    (m == 4'd3) ? LIM_10B : (m == 4'd10) ? LIM_REG : LIM_CMPA;
      end
      4'd8, 4'd9: begin
        c.dual = 1'b1;
        c.upd  = UPD_AT_ZERO;
        c.ovf  = OVF_AT_ZERO;
        c.lim_src = (m == 4'd8) ? LIM_REG : LIM_CMPA;
      end
      4'd5, 4'd6, 4'd7, 4'd14, 4'd15: begin
        c.upd = UPD_AT_ZERO;
        c.ovf = OVF_AT_LIM;
        c.lim_src = (m == 4'd5) ? LIM_8B : (m == 4'd6) ? LIM_9B :
                    (m == 4'd7) ? LIM_10B : (m == 4'd14) ? LIM_REG : LIM_CMPA;
      end
      default: c.run = 1'b0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pwm_mode_decode.sv
module pwm_mode_decode
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [3:0]       mode,
  input  logic [CNT_W-1:0] lim_reg,
  input  logic [CNT_W-1:0] cmpa_act,
  output mode_cfg_t        cfg,
  output logic [CNT_W-1:0] lim_val
);

  localparam int FIX8_W  = 8;
  localparam int FIX9_W  = 9;
  localparam int FIX10_W = 10;

  function automatic logic [CNT_W-1:0] low_ones(int k);
    logic [CNT_W-1:0] v;
    v = '0;
    for (int i = 0; i < CNT_W; i++) begin
      if (i < k) v[i] = 1'b1;
    end
    return v;
  endfunction

  always_comb begin
    cfg = decode_mode(mode);
    case (cfg.lim_src)
      LIM_8B:   lim_val = low_ones(FIX8_W);
      LIM_9B:   lim_val = low_ones(FIX9_W);
      LIM_10B:  lim_val = low_ones(FIX10_W);
      LIM_REG:  lim_val = lim_reg;
      LIM_CMPA: lim_val = cmpa_act;
      default:  lim_val = '1;
    endcase
  end

endmodule

// File: rtl/pwm_cmp_reg.sv
module pwm_cmp_reg #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             imm,
  input  logic             load,
  output logic [CNT_W-1:0] act
);

  logic [CNT_W-1:0] held_q;
  logic [CNT_W-1:0] act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
      act_q  <= '0;
    end else begin
      if (wr) held_q <= wdata;
      if (imm && wr)      act_q <= wdata;
      else if (!imm && load) act_q <= held_q;
    end
  end

  assign act = act_q;

  // R7
  act_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && !load) |=> $stable(act_q));

  // R7
  act_buffered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!imm && !load) |=> $stable(act_q));

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             dual,
  input  logic [CNT_W-1:0] lim,
  output logic [CNT_W-1:0] cnt,
  output logic             dir_down,
  output logic             ev_lim,
  output logic             ev_zero,
  output logic             ev_full
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dir_q, dir_d;
  logic             step;

  function automatic logic [CNT_W-1:0] next_single(logic [CNT_W-1:0] c,
                                                   logic [CNT_W-1:0] l);
    return (c == l) ? '0 : c + 1'b1;
  endfunction

  assign step = tick && run;

  always_comb begin
    cnt_d = cnt_q;
    dir_d = 1'b0;
    if (!dual) begin
      cnt_d = next_single(cnt_q, lim);
    end else if (!dir_q) begin
      if (cnt_q >= lim) begin
        dir_d = 1'b1;
        cnt_d = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      if (cnt_q == '0) begin
        dir_d = 1'b0;
        cnt_d = (lim == '0) ? '0 : {{(CNT_W-1){1'b0}}, 1'b1};
      end else begin
        dir_d = 1'b1;
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else if (step) begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign cnt      = cnt_q;
  assign dir_down = dual && dir_q;
  assign ev_lim   = step && (cnt_q == lim);
  assign ev_zero  = step && (cnt_q == '0) && (!dual || dir_q);
  assign ev_full  = step && (cnt_q == '1);

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q) && $stable(dir_q));

  // R6
  dual_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && dual && !dir_q && cnt_q < lim) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R5
  single_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !dual && cnt_q == lim) |=> (cnt_q == '0));

  // R10
  rsvd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt_q));

endmodule

// File: rtl/pwm_timer_core.sv
module pwm_timer_core
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_mode_lo,
  input  logic             wr_mode_hi,
  input  logic             wr_cmpa,
  input  logic             wr_cmpb,
  input  logic             wr_top,
  input  logic [CNT_W-1:0] wdata,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] count,
  output logic             dir_down,
  output logic             match_a,
  output logic             match_b,
  output logic             at_top,
  output logic             at_bottom,
  output logic             ovf_flag
);

  localparam int NUM_CMP = 2;

  logic [1:0]       mode_lo_q, mode_hi_q;
  logic [3:0]       mode;
  logic [CNT_W-1:0] lim_reg_q;
  mode_cfg_t        cfg;
  logic [CNT_W-1:0] lim_val;
  logic [CNT_W-1:0] cmp_act [NUM_CMP];
  logic [NUM_CMP-1:0] cmp_wr;
  logic [NUM_CMP-1:0] cmp_hit;
  logic             ev_lim, ev_zero, ev_full;
  logic             upd_imm, upd_load;
  logic             ovf_set;
  logic             ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_lo_q <= '0;
      mode_hi_q <= '0;
      lim_reg_q <= '0;
    end else begin
      if (wr_mode_lo) mode_lo_q <= wdata[1:0];
      if (wr_mode_hi) mode_hi_q <= wdata[1:0];
      if (wr_top)     lim_reg_q <= wdata;
    end
  end

  assign mode = {mode_hi_q, mode_lo_q};

  pwm_mode_decode #(.CNT_W(CNT_W)) u_decode (
    .mode     (mode),
    .lim_reg  (lim_reg_q),
    .cmpa_act (cmp_act[0]),
    .cfg      (cfg),
    .lim_val  (lim_val)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .run      (cfg.run),
    .dual     (cfg.dual),
    .lim      (lim_val),
    .cnt      (count),
    .dir_down (dir_down),
    .ev_lim   (ev_lim),
    .ev_zero  (ev_zero),
    .ev_full  (ev_full)
  );

  always_comb begin
    upd_imm  = (cfg.upd == UPD_NOW);
    upd_load = (cfg.upd == UPD_AT_LIM) ? ev_lim :
               (cfg.upd == UPD_AT_ZERO) ? ev_zero : 1'b0;
  end

  assign cmp_wr = {wr_cmpb, wr_cmpa};

  for (genvar i = 0; i < NUM_CMP; i++) begin : gen_cmp
    pwm_cmp_reg #(.CNT_W(CNT_W)) u_cmp (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (cmp_wr[i]),
      .wdata (wdata),
      .imm   (upd_imm),
      .load  (upd_load),
      .act   (cmp_act[i])
    );
    assign cmp_hit[i] = tick && cfg.run && (count == cmp_act[i]);
  end

  assign match_a   = cmp_hit[0];
  assign match_b   = cmp_hit[1];
  assign at_top    = ev_lim;
  assign at_bottom = ev_zero;

  always_comb begin
    case (cfg.ovf)
      OVF_AT_LIM:  ovf_set = ev_lim;
      OVF_AT_ZERO: ovf_set = ev_zero;
      default:     ovf_set = ev_full;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf_q <= 1'b0;
    else if (ovf_set) ovf_q <= 1'b1;
    else if (ovf_clr) ovf_q <= 1'b0;
  end

  assign ovf_flag = ovf_q;

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr) |=> ovf_q);

  // R8
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_set |=> ovf_q);

  // R8
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clr && !ovf_set) |=> !ovf_q);

  // R10
  rsvd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RESERVED) |-> !at_top && !at_bottom && !match_a && !match_b);

endmodule

// File: tb/tb_pwm_timer_core.sv
module tb_pwm_timer_core;

  typedef enum int {S_CNT, S_DIR, S_MA, S_MB, S_TOP, S_BOT, S_OVF} sig_e;
  typedef struct {
    string req;
    sig_e  sig;
    int    exp;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_mode_lo = 1'b0, wr_mode_hi = 1'b0;
  logic        wr_cmpa = 1'b0, wr_cmpb = 1'b0, wr_top = 1'b0;
  logic [15:0] wdata = '0;
  logic        ovf_clr = 1'b0;
  logic [15:0] count;
  logic        dir_down, match_a, match_b, at_top, at_bottom, ovf_flag;

  int   n_checks = 0;
  int   n_fails  = 0;
  bit   done     = 1'b0;
  item_t sb_q[$];
  event  chk_ev;

  pwm_timer_core dut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .wr_mode_lo(wr_mode_lo), .wr_mode_hi(wr_mode_hi),
    .wr_cmpa(wr_cmpa), .wr_cmpb(wr_cmpb), .wr_top(wr_top),
    .wdata(wdata), .ovf_clr(ovf_clr),
    .count(count), .dir_down(dir_down), .match_a(match_a), .match_b(match_b),
    .at_top(at_top), .at_bottom(at_bottom), .ovf_flag(ovf_flag)
  );

  always #5 clk = ~clk;

  function automatic int observe(sig_e s);
    case (s)
      S_CNT:   return int'(count);
      S_DIR:   return int'(dir_down);
      S_MA:    return int'(match_a);
      S_MB:    return int'(match_b);
      S_TOP:   return int'(at_top);
      S_BOT:   return int'(at_bottom);
      default: return int'(ovf_flag);
    endcase
  endfunction

  // monitor: pops expected items and compares with the ports
  initial begin
    forever begin
      @(chk_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        int act;
        it = sb_q.pop_front();
        act = observe(it.sig);
        n_checks++;
        if (act != it.exp) begin
          n_fails++;
          $display("FAIL %s %s: actual %0d expected %0d", it.req, it.sig.name(), act, it.exp);
        end
      end
    end
  end

  task automatic expect_sig(string req, sig_e s, int v);
    sb_q.push_back('{req: req, sig: s, exp: v});
  endtask

  task automatic flush();
    -> chk_ev;
    wait (sb_q.size() == 0);
  endtask

  task automatic ticks(int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic idle();
    tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    tick = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic set_mode(logic [3:0] m);
    tick = 1'b0;
    wdata = {14'd0, m[1:0]};
    wr_mode_lo = 1'b1;
    @(negedge clk);
    wr_mode_lo = 1'b0;
    wdata = {14'd0, m[3:2]};
    wr_mode_hi = 1'b1;
    @(negedge clk);
    wr_mode_hi = 1'b0;
  endtask

  task automatic write_reg(int which, logic [15:0] v);
    tick = 1'b0;
    wdata = v;
    if (which == 0) wr_cmpa = 1'b1;
    else if (which == 1) wr_cmpb = 1'b1;
    else wr_top = 1'b1;
    @(negedge clk);
    wr_cmpa = 1'b0; wr_cmpb = 1'b0; wr_top = 1'b0;
  endtask

  task automatic clear_ovf();
    tick = 1'b0;
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    expect_sig("R1", S_CNT, 0); expect_sig("R1", S_DIR, 0); expect_sig("R1", S_OVF, 0);
    flush();

    // R2 normal counting and hold
    ticks(10); idle();
    expect_sig("R2", S_CNT, 10); flush();
    idle(); idle();
    expect_sig("R2", S_CNT, 10); flush();
    ticks(65525);
    expect_sig("R2", S_CNT, 65535); expect_sig("R2", S_TOP, 1); expect_sig("R8", S_OVF, 0);
    flush();
    ticks(1);
    expect_sig("R2", S_CNT, 0); expect_sig("R8", S_OVF, 1); flush();
    clear_ovf();
    expect_sig("R8", S_OVF, 0); flush();

    // R3 mode 4, limit from compare A, compare B match
    set_mode(4'd4);
    write_reg(0, 16'd5);
    write_reg(1, 16'd3);
    ticks(3);
    expect_sig("R9", S_CNT, 3); expect_sig("R9", S_MB, 1); expect_sig("R9", S_MA, 0); flush();
    ticks(2);
    expect_sig("R3", S_CNT, 5); expect_sig("R9", S_MA, 1); expect_sig("R3", S_TOP, 1); flush();
    ticks(1);
    expect_sig("R3", S_CNT, 0); flush();

    // R3 mode 12, limit from limit register
    write_reg(2, 16'd2);
    set_mode(4'd12);
    ticks(2);
    expect_sig("R3", S_CNT, 2); expect_sig("R3", S_TOP, 1); flush();
    ticks(1);
    expect_sig("R3", S_CNT, 0); flush();
    ticks(1);

    // R10 reserved mode holds
    set_mode(4'd13);
    ticks(5);
    expect_sig("R10", S_CNT, 1); expect_sig("R10", S_TOP, 0); expect_sig("R10", S_MA, 0); flush();

    // R4 R5 fast 8-bit
    set_mode(4'd5);
    ticks(254);
    expect_sig("R4", S_CNT, 255); expect_sig("R5", S_TOP, 1); expect_sig("R8", S_OVF, 0); flush();
    ticks(1);
    expect_sig("R5", S_CNT, 0); expect_sig("R8", S_OVF, 1); expect_sig("R5", S_BOT, 1); flush();
    clear_ovf();

    // R7 single-slope buffer loads at zero
    ticks(3);
    write_reg(0, 16'h0040);
    ticks(2);
    expect_sig("R7", S_CNT, 5); expect_sig("R7", S_MA, 1); flush();
    ticks(59);
    expect_sig("R7", S_CNT, 64); expect_sig("R7", S_MA, 0); flush();
    ticks(192);
    expect_sig("R5", S_CNT, 0); flush();
    ticks(64);
    expect_sig("R7", S_CNT, 64); expect_sig("R7", S_MA, 1); flush();

    // R6 R4 dual-slope 8-bit
    do_reset();
    set_mode(4'd1);
    ticks(255);
    expect_sig("R4", S_CNT, 255); expect_sig("R6", S_DIR, 0); expect_sig("R6", S_TOP, 1); flush();
    ticks(1);
    expect_sig("R6", S_CNT, 254); expect_sig("R6", S_DIR, 1); flush();
    ticks(254);
    expect_sig("R6", S_CNT, 0); expect_sig("R6", S_DIR, 1); expect_sig("R8", S_OVF, 0); flush();
    ticks(1);
    expect_sig("R6", S_CNT, 1); expect_sig("R6", S_DIR, 0); expect_sig("R8", S_OVF, 1); flush();

    // R7 phase-correct buffer loads at the limit
    write_reg(1, 16'h0010);
    ticks(15);
    expect_sig("R7", S_CNT, 16); expect_sig("R7", S_MB, 0); flush();
    ticks(239);
    ticks(1);
    expect_sig("R6", S_CNT, 254); flush();
    ticks(238);
    expect_sig("R7", S_CNT, 16); expect_sig("R7", S_MB, 1); expect_sig("R6", S_DIR, 1); flush();

    // R11 mode 15 limit from active compare A
    do_reset();
    set_mode(4'd15);
    write_reg(0, 16'd3);
    ticks(1);
    expect_sig("R11", S_CNT, 0); flush();
    ticks(3);
    expect_sig("R11", S_CNT, 3); expect_sig("R11", S_TOP, 1); flush();
    ticks(1);
    expect_sig("R11", S_CNT, 0); flush();

    // R11 mode 14 limit from limit register
    do_reset();
    set_mode(4'd14);
    write_reg(2, 16'd4);
    ticks(4);
    expect_sig("R11", S_CNT, 4); expect_sig("R11", S_TOP, 1); flush();
    ticks(1);
    expect_sig("R11", S_CNT, 0); flush();

    // R7 R8 mode 9 buffer loads at falling zero
    do_reset();
    set_mode(4'd9);
    write_reg(0, 16'd3);
    ticks(2);
    expect_sig("R7", S_CNT, 0); expect_sig("R6", S_DIR, 0); expect_sig("R8", S_OVF, 1); flush();
    ticks(1);
    expect_sig("R7", S_CNT, 1); flush();
    ticks(2);
    expect_sig("R11", S_CNT, 3); flush();
    ticks(1);
    expect_sig("R6", S_CNT, 2); expect_sig("R6", S_DIR, 1); flush();
    idle();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule